// File: doc/BRIEF.md
# Skewed Multi-Bank Matrix Memory

This block holds an N x N matrix of fixed-width elements spread over parallel single-port memory banks. Element (i,j), counted from zero, lives in bank (i+j) mod NB at local word i, where NB is the number of banks. With this skewed placement a whole row or a whole column touches every bank exactly once, so either can be read or written as one vector in a single cycle. Its typical use is feeding a matrix product, where a row of one operand and a column of the other are needed side by side.

The requester presents an access mode, an index and read and/or write strobes, together with a full vector of element data. The block derives each bank's local address and a lane-to-bank crossbar from the mode and index. On a write the vector is scattered to the banks. On a read the bank outputs are gathered back so that lane k holds element k of the requested vector. With the diagonal option set, the block uses N+1 banks. An odd bank count makes 2k mod NB distinct for every lane, so the main diagonal also becomes conflict-free. In that configuration one bank idles during row and column accesses.

Top module: `skew_matrix_mem`

## Requirements
- R1: Row mode (mode = 0): lane k (bits k*DW +: DW) of the vector carries element (idx, k), for both reads and writes, completed in one cycle.
- R2: Column mode (mode = 1): lane k of the vector carries element (k, idx), for both reads and writes, completed in one cycle.
- R3: Diagonal mode (mode = 2) with DIAG_EN = 1: lane k of the vector carries element (k, k), for both reads and writes, completed in one cycle.
- R4: Row, column and diagonal accesses share one storage: an element written through any mode reads back unchanged through every other mode that covers it.
- R5: `rd_data` and `rd_valid` appear one cycle after an accepted `rd_en`. `rd_valid` is low in the cycle after any cycle without an accepted read.
- R6: When `rd_en` and `wr_en` are both high in one cycle, the read returns the contents from before that write. The written data are visible to the next access.
- R7: A request in mode 3, or in mode 2 when DIAG_EN = 0, raises `err` one cycle later with `rd_valid` low, and leaves the stored matrix unchanged.
- R8: Every accepted write enables exactly N distinct banks, so no two lanes ever meet in the same bank.
- R9: After reset, `rd_valid` and `err` are low and `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 row, 1 column, 2 diagonal, 3 reserved |
| idx | input | $clog2(N) | Row or column number (ignored in diagonal mode) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | N*DW | Write vector, lane k at bits k*DW +: DW |
| rd_data | output | N*DW | Read vector, lane k at bits k*DW +: DW |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| err | output | 1 | Illegal mode for this configuration, one cycle after the request |

## Verification
The bench fills the matrix through rows, through columns and through the diagonal. After each fill it reads back every row, every column and the diagonal. A wrong skew, a wrong local address or a crossbar rotated the wrong way would surface as lanes holding a neighbouring element. Two instances run side by side, one with four banks and one with five. A diagonal write must then change only the five-bank copy, and a design that let the four-bank copy write with colliding lanes would corrupt its rows. A combined read and write must show the old row, which catches a write-first bank, and reserved-mode writes must leave every row intact.

// File: rtl/skew_matrix_pkg.sv
package skew_matrix_pkg;

    typedef enum logic [1:0] {
        ACC_ROW  = 2'd0,
        ACC_COL  = 2'd1,
        ACC_DIAG = 2'd2,
        ACC_RSVD = 2'd3
    } acc_mode_e;

endpackage

// File: rtl/skew_lane_map.sv
module skew_lane_map
    import skew_matrix_pkg::*;
#(
    parameter int N       = 4,
    parameter bit DIAG_EN = 1'b0,
    parameter int NB      = DIAG_EN ? N + 1 : N,
    parameter int BW      = $clog2(NB),
    parameter int IW      = $clog2(N)
) (
    input  logic [1:0]                 mode,
    input  logic [IW-1:0]              idx,
    output logic [N-1:0][BW-1:0]       lane_bank,
    output logic [N-1:0][IW-1:0]       lane_addr,
    output logic                       mode_ok
);

    always_comb begin
        mode_ok = 1'b0;
        for (int k = 0; k < N; k++) begin
            lane_bank[k] = BW'(k);
            lane_addr[k] = '0;
        end
        case (acc_mode_e'(mode))
            ACC_ROW: begin
                mode_ok = 1'b1;
                for (int k = 0; k < N; k++) begin
                    lane_bank[k] = BW'((int'(idx) + k) % NB);
                    lane_addr[k] = idx;
                end
            end
            ACC_COL: begin
                mode_ok = 1'b1;
                for (int k = 0; k < N; k++) begin
                    lane_bank[k] = BW'((k + int'(idx)) % NB);
                    lane_addr[k] = IW'(k);
                end
            end
            ACC_DIAG: begin
                mode_ok = DIAG_EN;
                for (int k = 0; k < N; k++) begin
                    lane_bank[k] = BW'((2 * k) % NB);
                    lane_addr[k] = IW'(k);
                end
            end
            default: mode_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/skew_bank_xbar.sv
module skew_bank_xbar #(
    parameter int N  = 4,
    parameter int NB = 4,
    parameter int DW = 8,
    parameter int BW = $clog2(NB),
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0][BW-1:0]  lane_bank,
    input  logic [N-1:0][IW-1:0]  lane_addr,
    input  logic [N*DW-1:0]       wr_data,
    output logic [NB-1:0]         bank_sel,
    output logic [NB-1:0][IW-1:0] bank_addr,
    output logic [NB-1:0][DW-1:0] bank_wd
);

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_sel[b]  = 1'b0;
            bank_addr[b] = '0;
            bank_wd[b]   = '0;
            for (int k = 0; k < N; k++) begin
                if (lane_bank[k] == BW'(b)) begin
                    bank_sel[b]  = 1'b1;
                    bank_addr[b] = lane_addr[k];
                    bank_wd[b]   = wr_data[k*DW +: DW];
                end
            end
        end
    end

endmodule

// File: rtl/skew_bank.sv
module skew_bank #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (re) begin
            rd_d = mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wd;
        end
    end

    assign rd = rd_q;

endmodule

// File: rtl/skew_matrix_mem.sv
module skew_matrix_mem
    import skew_matrix_pkg::*;
#(
    parameter int N       = 4,
    parameter int DW      = 8,
    parameter bit DIAG_EN = 1'b0,
    localparam int NB     = DIAG_EN ? N + 1 : N,
    localparam int BW     = $clog2(NB),
    localparam int NBP    = 1 << BW,
    localparam int IW     = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [IW-1:0]   idx,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [N*DW-1:0] wr_data,
    output logic [N*DW-1:0] rd_data,
    output logic            rd_valid,
    output logic            err
);

    typedef struct packed {
        logic                 rd_valid;
        logic                 err;
        logic [N-1:0][BW-1:0] sel;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0][BW-1:0]  lane_bank;
    logic [N-1:0][IW-1:0]  lane_addr;
    logic                  mode_ok;
    logic [NB-1:0]         bank_sel;
    logic [NB-1:0][IW-1:0] bank_addr;
    logic [NB-1:0][DW-1:0] bank_wd;
    logic [NB-1:0]         bank_we;
    logic [NB-1:0]         bank_re;
    logic [NBP-1:0][DW-1:0] bank_rd;

    skew_lane_map #(
        .N(N), .DIAG_EN(DIAG_EN), .NB(NB), .BW(BW), .IW(IW)
    ) u_map (
        .mode      (mode),
        .idx       (idx),
        .lane_bank (lane_bank),
        .lane_addr (lane_addr),
        .mode_ok   (mode_ok)
    );

    skew_bank_xbar #(
        .N(N), .NB(NB), .DW(DW), .BW(BW), .IW(IW)
    ) u_xbar (
        .lane_bank (lane_bank),
        .lane_addr (lane_addr),
        .wr_data   (wr_data),
        .bank_sel  (bank_sel),
        .bank_addr (bank_addr),
        .bank_wd   (bank_wd)
    );

    assign bank_we = (wr_en && mode_ok) ? bank_sel : '0;
    assign bank_re = (rd_en && mode_ok) ? bank_sel : '0;

    for (genvar b = 0; b < NBP; b++) begin : g_bank
        if (b < NB) begin : g_real
            skew_bank #(.DEPTH(N), .DW(DW), .AW(IW)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .re    (bank_re[b]),
                .we    (bank_we[b]),
                .addr  (bank_addr[b]),
                .wd    (bank_wd[b]),
                .rd    (bank_rd[b])
            );
        end else begin : g_pad
            assign bank_rd[b] = '0;
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en && mode_ok;
        st_d.err      = (rd_en || wr_en) && !mode_ok;
        if (rd_en && mode_ok) begin
            st_d.sel = lane_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int k = 0; k < N; k++) begin
            rd_data[k*DW +: DW] = bank_rd[st_q.sel[k]];
        end
    end

    assign rd_valid = st_q.rd_valid;
    assign err      = st_q.err;

endmodule

module skew_matrix_mem_chk #(
    parameter int N       = 4,
    parameter int NB      = 4,
    parameter bit DIAG_EN = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          rd_en,
    input logic          wr_en,
    input logic          rd_valid,
    input logic          err,
    input logic [NB-1:0] bank_we
);

    logic legal;
    assign legal = (mode == 2'd0) || (mode == 2'd1) || ((mode == 2'd2) && DIAG_EN);

    // R5
    a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && legal) |=> rd_valid);
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R7
    a_r7_err_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !legal) |=> (err && !rd_valid));
    a_r7_no_write_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal) |-> (bank_we == '0));
    a_r7_err_only_after_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd_en || wr_en) && !legal) |=> !err);
    // R8
    a_r8_conflict_free: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && legal) |-> ($countones(bank_we) == N));
    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (bank_we == '0));

endmodule

bind skew_matrix_mem skew_matrix_mem_chk #(
    .N(N), .NB(NB), .DIAG_EN(DIAG_EN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rd_valid (rd_valid),
    .err      (err),
    .bank_we  (bank_we)
);

// File: tb/skew_matrix_mem_tb.sv
module skew_matrix_mem_tb;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode = '0;
    logic [IW-1:0]   idx = '0;
    logic            rd_en = 1'b0;
    logic            wr_en = 1'b0;
    logic [N*DW-1:0] wr_data = '0;
    logic [N*DW-1:0] rd_data0, rd_data1;
    logic            rd_valid0, rd_valid1, err0, err1;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DW-1:0] refm [2][N][N];

    always #5 clk = ~clk;

    skew_matrix_mem #(.N(N), .DW(DW), .DIAG_EN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .idx(idx),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data0), .rd_valid(rd_valid0), .err(err0)
    );

    skew_matrix_mem #(.N(N), .DW(DW), .DIAG_EN(1'b1)) u_dut_diag (
        .clk(clk), .rst_n(rst_n), .mode(mode), .idx(idx),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data1), .rd_valid(rd_valid1), .err(err1)
    );

    function automatic bit legal(int inst, int m);
        return (m == 0) || (m == 1) || (m == 2 && inst == 1);
    endfunction

    function automatic int row_of(int m, int ix, int k);
        return (m == 0) ? ix : k;
    endfunction

    function automatic int col_of(int m, int ix, int k);
        return (m == 1) ? ix : k;
    endfunction

    function automatic logic [N*DW-1:0] expected(int inst, int m, int ix);
        logic [N*DW-1:0] v;
        for (int k = 0; k < N; k++) begin
            v[k*DW +: DW] = refm[inst][row_of(m, ix, k)][col_of(m, ix, k)];
        end
        return v;
    endfunction

    function automatic logic [N*DW-1:0] pattern(int m, int ix, int seed);
        logic [N*DW-1:0] v;
        for (int k = 0; k < N; k++) begin
            v[k*DW +: DW] = DW'(seed + 16 * row_of(m, ix, k) + col_of(m, ix, k));
        end
        return v;
    endfunction

    task automatic check(string tag, int inst, logic [N*DW-1:0] act, logic [N*DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d: actual %h expected %h", tag, inst, act, exp);
        end
    endtask

    task automatic op(string tag, int m, int ix, bit rd, bit wr, logic [N*DW-1:0] wd);
        logic [N*DW-1:0] exp [2];
        for (int i = 0; i < 2; i++) exp[i] = (m == 3) ? '0 : expected(i, m, ix);
        @(negedge clk);
        mode    = 2'(m);
        idx     = IW'(ix);
        rd_en   = rd;
        wr_en   = wr;
        wr_data = wd;
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        for (int i = 0; i < 2; i++) begin
            logic [N*DW-1:0] rdv;
            logic            vv, ee;
            rdv = (i == 0) ? rd_data0 : rd_data1;
            vv  = (i == 0) ? rd_valid0 : rd_valid1;
            ee  = (i == 0) ? err0 : err1;
            if (legal(i, m)) begin
                check({tag, " err"}, i, N*DW'(ee), '0);
                check({tag, " valid"}, i, N*DW'(vv), N*DW'(rd));
                if (rd) check({tag, " data"}, i, rdv, exp[i]);
                if (wr) begin
                    for (int k = 0; k < N; k++)
                        refm[i][row_of(m, ix, k)][col_of(m, ix, k)] = wd[k*DW +: DW];
                end
            end else if (rd || wr) begin
                check({tag, " R7 err"}, i, N*DW'(ee), N*DW'(1));
                check({tag, " R7 valid"}, i, N*DW'(vv), '0);
            end
        end
    endtask

    task automatic read_all_rows(string tag);
        for (int r = 0; r < N; r++) op(tag, 0, r, 1'b1, 1'b0, '0);
    endtask

    task automatic read_all_cols(string tag);
        for (int c = 0; c < N; c++) op(tag, 1, c, 1'b1, 1'b0, '0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++)
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) refm[i][r][c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 data", 0, rd_data0, '0);
        check("R9 data", 1, rd_data1, '0);
        check("R9 flags", 0, N*DW'({rd_valid0, err0}), '0);
        check("R9 flags", 1, N*DW'({rd_valid1, err1}), '0);

        // R1: fill by rows, then read every orientation
        for (int r = 0; r < N; r++) op("R1 wr", 0, r, 1'b0, 1'b1, pattern(0, r, 8'h10));
        read_all_rows("R1 rd");
        read_all_cols("R2 R4 col after row fill");
        op("R3 diag after row fill", 2, 0, 1'b1, 1'b0, '0);

        // R2: fill by columns
        for (int c = 0; c < N; c++) op("R2 wr", 1, c, 1'b0, 1'b1, pattern(1, c, 8'h40));
        read_all_rows("R4 row after col fill");
        read_all_cols("R2 rd");
        op("R3 diag after col fill", 2, 1, 1'b1, 1'b0, '0);

        // R3: diagonal write, rejected on the 4-bank instance (R7)
        op("R3 diag wr", 2, 0, 1'b0, 1'b1, pattern(2, 0, 8'hA0));
        op("R3 diag rd", 2, 3, 1'b1, 1'b0, '0);
        read_all_rows("R4 R7 rows after diag wr");
        read_all_cols("R4 cols after diag wr");

        // R7: reserved mode write and read leave storage alone
        op("R7 rsvd wr", 3, 2, 1'b0, 1'b1, {N*DW{1'b1}});
        op("R7 rsvd rd", 3, 1, 1'b1, 1'b0, '0);
        read_all_rows("R7 rows after rsvd");

        // R6: simultaneous read and write returns the old row
        op("R6 rd+wr row", 0, 1, 1'b1, 1'b1, pattern(0, 1, 8'hC3));
        op("R6 new row", 0, 1, 1'b1, 1'b0, '0);
        op("R6 rd+wr col", 1, 2, 1'b1, 1'b1, pattern(1, 2, 8'h55));
        read_all_cols("R6 cols after");

        // R5: no valid without a read
        op("R5 wr only", 0, 3, 1'b0, 1'b1, pattern(0, 3, 8'h07));
        op("R5 idle", 0, 0, 1'b0, 1'b0, '0);
        read_all_rows("R5 final rows");

        report();
        $finish;
    end

endmodule